// File: doc/BRIEF.md
# Storage Key Protection Checker

This block decides, for every main-storage reference, whether the reference may proceed. Storage is split into blocks of 2048 bytes, and each block carries a 5-bit storage key. The upper four bits of the key are a lock code. The lowest bit marks the block as protected against reads as well as writes. A requester presents a byte address, a 4-bit access key and a flag saying whether it is a store or a fetch. One clock later the block reports either a grant or a protection violation. It also produces a write enable that a downstream storage array can use directly.

Lock codes 1 to 15 separate up to fifteen protected programs, and any number of blocks may share a code. Access key zero is a master key and passes every check. Blocks that are not read-protected accept fetches under any key, but stores to them are still checked. A separate key port lets supervisory logic assign a block's key by byte address and read it back.

The number of blocks held is a parameter and must be a power of two. The entry index is taken from the address bits that start at bit 11. Address bits above the index width are ignored, so with fewer than 8192 blocks higher addresses alias onto lower ones.

Top module: `skp_top`

## Requirements
- R1: After reset every key entry reads as 00000, and chk_valid, chk_grant, chk_violation, mem_we, key_rvalid and key_rdata are all 0.
- R2: The key entry is selected by address bits [11+log2(NUM_BLKS)-1:11]. Bits [10:0] and every bit above the index field have no effect on which entry is used.
- R3: Asserting key_wr_en stores key_wdata into the addressed entry, with bits [4:1] as the lock code and bit 0 as the fetch-protect flag. Asserting key_rd_en returns that entry on key_rdata with key_rvalid high one clock later. key_rdata is 0 while key_rvalid is low.
- R4: A store (acc_store=1) is granted when acc_key equals the entry's lock code or acc_key is 0000. Otherwise it is a violation.
- R5: A fetch (acc_store=0) to an entry whose fetch-protect bit is 1 follows the same match-or-zero rule as a store.
- R6: A fetch to an entry whose fetch-protect bit is 0 is granted for every access key.
- R7: chk_valid rises exactly one clock after acc_valid. While chk_valid is high, exactly one of chk_grant and chk_violation is high.
- R8: mem_we is high exactly in the cycle that reports a granted store. It stays low for fetches and for violating stores.
- R9: When a key write and a check or a key read hit the same entry in the same cycle, the check and the read both use the entry's value from before the write.
- R10: In a cycle after one with acc_valid low, chk_valid, chk_grant, chk_violation and mem_we are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr_en | input | 1 | Assign key to addressed block |
| key_rd_en | input | 1 | Read key of addressed block |
| key_addr | input | 24 | Byte address for key operations |
| key_wdata | input | 5 | Key to assign: lock code [4:1], fetch-protect [0] |
| key_rvalid | output | 1 | key_rdata holds a read result |
| key_rdata | output | 5 | Key read back |
| acc_valid | input | 1 | Storage reference present |
| acc_addr | input | 24 | Byte address of reference |
| acc_key | input | 4 | Access key of requester |
| acc_store | input | 1 | 1 = store, 0 = fetch |
| chk_valid | output | 1 | Check result present |
| chk_grant | output | 1 | Reference allowed |
| chk_violation | output | 1 | Reference refused |
| mem_we | output | 1 | Write enable for a granted store |

## Verification
The bench builds the block with NUM_BLKS = 16, so the index field is only address bits [14:11]. Random addresses therefore set the ignored upper bits often, which exercises aliasing between blocks. Sixteen entries also make key writes and checks collide on the same block frequently, which covers the same-cycle old-value rule. With a small table, every entry can be read back right after reset, and random lock codes match the random access key often enough that both grants and violations appear.

// File: rtl/skp_pkg.sv
package skp_pkg;
    localparam int ADDR_W    = 24;
    localparam int BLK_SHIFT = 11;
    localparam int LOCK_W    = 4;
    localparam int SKEY_W    = LOCK_W + 1;

    // storage key: lock code in the upper bits, fetch-protect in bit 0
    typedef struct packed {
        logic [LOCK_W-1:0] lock;
        logic              fprot;
    } skey_t;

    // registered outputs of the top
    typedef struct packed {
        logic              chk_valid;
        logic              chk_grant;
        logic              chk_violation;
        logic              mem_we;
        logic              key_rvalid;
        logic [SKEY_W-1:0] key_rdata;
    } outreg_t;
endpackage

// File: rtl/skp_blk_index.sv
module skp_blk_index
    import skp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] unused_addr;

    assign unused_addr = addr;
    assign idx         = addr[BLK_SHIFT +: IDX_W];
endmodule

// File: rtl/skp_key_table.sv
module skp_key_table
    import skp_pkg::*;
#(
    parameter int NUM_BLKS = 64,
    localparam int IDX_W   = $clog2(NUM_BLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  skey_t            wr_key,
    input  logic [IDX_W-1:0] rd_idx_acc,
    output skey_t            rd_key_acc,
    input  logic [IDX_W-1:0] rd_idx_sw,
    output skey_t            rd_key_sw
);
    skey_t tab_q [NUM_BLKS];
    skey_t tab_d [NUM_BLKS];

    // both read ports see the value held before any write in this cycle
    assign rd_key_acc = tab_q[rd_idx_acc];
    assign rd_key_sw  = tab_q[rd_idx_sw];

    always_comb begin
        for (int i = 0; i < NUM_BLKS; i++) begin
            tab_d[i] = tab_q[i];
        end
        if (wr_en) begin
            tab_d[wr_idx] = wr_key;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLKS; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_BLKS; i++) begin
                tab_q[i] <= tab_d[i];
            end
        end
    end
endmodule

// File: rtl/skp_access_rule.sv
module skp_access_rule
    import skp_pkg::*;
(
    input  skey_t             entry,
    input  logic [LOCK_W-1:0] acc_key,
    input  logic              is_store,
    output logic              grant
);
    logic master;
    logic match;
    logic needs_check;

    always_comb begin
        master      = (acc_key == '0);
        match       = (acc_key == entry.lock);
        needs_check = is_store | entry.fprot;
        grant       = !needs_check || master || match;
    end
endmodule

// File: rtl/skp_top.sv
module skp_top
    import skp_pkg::*;
#(
    parameter int NUM_BLKS = 64,
    localparam int IDX_W   = $clog2(NUM_BLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_en,
    input  logic              key_rd_en,
    input  logic [ADDR_W-1:0] key_addr,
    input  logic [SKEY_W-1:0] key_wdata,
    output logic              key_rvalid,
    output logic [SKEY_W-1:0] key_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LOCK_W-1:0] acc_key,
    input  logic              acc_store,
    output logic              chk_valid,
    output logic              chk_grant,
    output logic              chk_violation,
    output logic              mem_we
);
    logic [IDX_W-1:0] key_idx;
    logic [IDX_W-1:0] acc_idx;
    skey_t            acc_entry;
    skey_t            sw_entry;
    logic             rule_grant;
    outreg_t          st_d;
    outreg_t          st_q;

    skp_blk_index #(.IDX_W(IDX_W)) u_key_index (
        .addr (key_addr),
        .idx  (key_idx)
    );

    skp_blk_index #(.IDX_W(IDX_W)) u_acc_index (
        .addr (acc_addr),
        .idx  (acc_idx)
    );

    skp_key_table #(.NUM_BLKS(NUM_BLKS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (key_wr_en),
        .wr_idx     (key_idx),
        .wr_key     (skey_t'(key_wdata)),
        .rd_idx_acc (acc_idx),
        .rd_key_acc (acc_entry),
        .rd_idx_sw  (key_idx),
        .rd_key_sw  (sw_entry)
    );

    skp_access_rule u_rule (
        .entry    (acc_entry),
        .acc_key  (acc_key),
        .is_store (acc_store),
        .grant    (rule_grant)
    );

    always_comb begin
        st_d               = '0;
        st_d.chk_valid     = acc_valid;
        st_d.chk_grant     = acc_valid & rule_grant;
        st_d.chk_violation = acc_valid & ~rule_grant;
        st_d.mem_we        = acc_valid & acc_store & rule_grant;
        st_d.key_rvalid    = key_rd_en;
        st_d.key_rdata     = key_rd_en ? sw_entry : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chk_valid     = st_q.chk_valid;
    assign chk_grant     = st_q.chk_grant;
    assign chk_violation = st_q.chk_violation;
    assign mem_we        = st_q.mem_we;
    assign key_rvalid    = st_q.key_rvalid;
    assign key_rdata     = st_q.key_rdata;
endmodule

// File: rtl/skp_checker.sv
module skp_checker
    import skp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              key_rd_en,
    input logic              key_rvalid,
    input logic              acc_valid,
    input logic              acc_store,
    input logic [LOCK_W-1:0] acc_key,
    input logic              chk_valid,
    input logic              chk_grant,
    input logic              chk_violation,
    input logic              mem_we
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> ($countones({chk_grant, chk_violation}) == 1)); // R7
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> chk_valid); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(chk_valid || chk_grant || chk_violation || mem_we)); // R10
    AST_MASTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_key == '0) |=> chk_grant); // R4
    AST_WE_ONLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> chk_grant); // R8
    AST_NO_WE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_store) |=> !mem_we); // R8
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        key_rd_en |=> key_rvalid); // R3
endmodule

bind skp_top skp_checker u_skp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .key_rd_en     (key_rd_en),
    .key_rvalid    (key_rvalid),
    .acc_valid     (acc_valid),
    .acc_store     (acc_store),
    .acc_key       (acc_key),
    .chk_valid     (chk_valid),
    .chk_grant     (chk_grant),
    .chk_violation (chk_violation),
    .mem_we        (mem_we)
);

// File: tb/skp_top_bench.sv
module skp_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 16;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr_en = 1'b0, key_rd_en = 1'b0;
    logic [23:0] key_addr = '0;
    logic [4:0]  key_wdata = '0;
    logic        key_rvalid;
    logic [4:0]  key_rdata;
    logic        acc_valid = 1'b0, acc_store = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [3:0]  acc_key = '0;
    logic        chk_valid, chk_grant, chk_violation, mem_we;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;
    bit init_phase = 0;

    logic [4:0] ref_tab [NB];
    logic       e_valid, e_grant, e_viol, e_we, e_rvalid;
    logic [4:0] e_rdata;
    string      tag_acc, tag_rd;

    skp_top #(.NUM_BLKS(NB)) u_skp_top (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int bidx(logic [23:0] a);
        return (int'(a) / 2048) % NB;
    endfunction

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_tab[i]) ref_tab[i] = '0;
            {e_valid, e_grant, e_viol, e_we, e_rvalid} = '0;
            e_rdata = '0;
            tag_acc = "R1";
            tag_rd  = "R1";
        end else begin
            logic [4:0] ent;
            logic       g;
            ent = ref_tab[bidx(acc_addr)];
            g = (!acc_store && !ent[0]) || (acc_key == 4'd0) || (acc_key == ent[4:1]);
            e_valid  = acc_valid;
            e_grant  = acc_valid && g;
            e_viol   = acc_valid && !g;
            e_we     = acc_valid && acc_store && g;
            e_rvalid = key_rd_en;
            e_rdata  = key_rd_en ? ref_tab[bidx(key_addr)] : 5'd0;
            if (!acc_valid) tag_acc = "R10";
            else if (key_wr_en && bidx(key_addr) == bidx(acc_addr)) tag_acc = "R9";
            else if (acc_addr[23:15] != 0) tag_acc = "R2";
            else if (acc_store) tag_acc = "R4";
            else if (ent[0]) tag_acc = "R5";
            else tag_acc = "R6";
            if (init_phase) tag_rd = "R1";
            else if (key_wr_en && key_rd_en) tag_rd = "R9";
            else tag_rd = "R3";
            if (key_wr_en) ref_tab[bidx(key_addr)] = key_wdata;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            check("R7", {7'd0, chk_valid}, {7'd0, e_valid}, "chk_valid");
            check(tag_acc, {7'd0, chk_grant}, {7'd0, e_grant}, "chk_grant");
            check(tag_acc, {7'd0, chk_violation}, {7'd0, e_viol}, "chk_violation");
            check("R8", {7'd0, mem_we}, {7'd0, e_we}, "mem_we");
            check(tag_rd, {7'd0, key_rvalid}, {7'd0, e_rvalid}, "key_rvalid");
            check(tag_rd, {3'd0, key_rdata}, {3'd0, e_rdata}, "key_rdata");
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        key_wr_en = 0; key_rd_en = 0; acc_valid = 0;
    endtask

    task automatic setkey(int blk, logic [3:0] lock, logic fp);
        idle();
        key_wr_en = 1; key_addr = 24'(blk * 2048 + 5); key_wdata = {lock, fp};
        step();
    endtask

    task automatic access(logic [23:0] a, logic [3:0] k, logic st);
        idle();
        acc_valid = 1; acc_addr = a; acc_key = k; acc_store = st;
        step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        // R1: every entry reads back as zero after reset
        init_phase = 1;
        for (int b = 0; b < NB; b++) begin
            idle(); key_rd_en = 1; key_addr = 24'(b * 2048); step();
        end
        init_phase = 0;
        setkey(3, 4'h5, 1'b1);
        setkey(4, 4'hA, 1'b0);
        access(24'(3 * 2048 + 17), 4'h5, 1'b1);   // R4 match
        access(24'(3 * 2048), 4'h6, 1'b1);        // R4 mismatch
        access(24'(3 * 2048 + 2047), 4'h0, 1'b1); // R4 master key
        access(24'(3 * 2048), 4'h6, 1'b0);        // R5 protected fetch
        access(24'(3 * 2048), 4'h5, 1'b0);        // R5 matching fetch
        access(24'(4 * 2048), 4'h6, 1'b0);        // R6 unprotected fetch
        access(24'(4 * 2048), 4'h6, 1'b1);        // R4 store still checked
        // R9: write and check the same block together
        idle();
        key_wr_en = 1; key_rd_en = 1; key_addr = 24'(4 * 2048); key_wdata = {4'h6, 1'b1};
        acc_valid = 1; acc_addr = 24'(4 * 2048 + 9); acc_key = 4'h6; acc_store = 1;
        step();
        access(24'(4 * 2048), 4'h6, 1'b1);
        // R2: upper address bits alias onto block 3
        access(24'h8000 + 24'(3 * 2048), 4'h5, 1'b1);
        access(24'hFF0000 + 24'(3 * 2048), 4'h7, 1'b1);
        idle(); step();
        for (int i = 0; i < 400; i++) begin
            key_wr_en = ($urandom % 4) == 0;
            key_rd_en = ($urandom % 3) == 0;
            key_addr  = 24'($urandom);
            key_wdata = 5'($urandom);
            acc_valid = ($urandom % 4) != 0;
            acc_addr  = 24'($urandom);
            acc_key   = (($urandom % 5) == 0) ? 4'd0 : 4'($urandom);
            acc_store = 1'($urandom);
            step();
        end
        idle();
        step();
        step();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule